// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt requests for a DSP core and decides which one the core services next. It has three external request lines, three internal event pulses (timer, serial receive, serial transmit), a software trap request and a reset request. The external lines pass through a synchronizer and a rising-edge detector. Each maskable event latches into a flag register. A mask register, loaded by a data-space write to a fixed address, selects which flags may be serviced. A global enable gates all maskable sources.

At every instruction boundary, which is any cycle in which the core does not report busy, the controller picks the highest-priority source that is eligible. It then emits a one-cycle acknowledge together with the vector address of that source. Vectors are spaced two words apart, so each slot can hold a branch. While the core is busy with a multicycle, repeated or wait-stretched instruction, requests keep accumulating but none is taken.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A rising edge on an external line, seen after a two-stage synchronizer, sets its flag bit once; a line held high does not set the flag again. A one-cycle internal event pulse sets its flag bit. Flag bit positions: 0 = external line 0, 1 = external line 1, 2 = external line 2, 3 = timer, 4 = serial receive, 5 = serial transmit.
- R2: A write to data address 4 loads the low 6 bits of the write data into the mask register. Writes to any other address leave the mask unchanged.
- R3: Fixed priority: reset request first, then trap, then flag bits 0 to 5, with a lower bit meaning higher priority.
- R4: A flagged source is serviced only when its mask bit is 1 and the global enable is 1.
- R5: While the busy input is high, nothing is taken. Pending requests are held and are taken at the first non-busy cycle.
- R6: A take raises the acknowledge output for one cycle, with vector address = 2 × code. The codes are: reset 0, external 0 to 2 → 1 to 3, timer 4, serial receive 5, serial transmit 6, trap 7.
- R7: A take clears the serviced flag or pending request and clears the global enable. The enable-set command sets the global enable and the enable-clear command clears it; clear wins when both are given in the same cycle.
- R8: Trap and reset requests are taken regardless of the mask and the global enable.
- R9: After reset, flags, mask, global enable and acknowledge are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_irq_i | input | 3 | Asynchronous external request lines |
| tmr_evt_i | input | 1 | Timer event pulse |
| srx_evt_i | input | 1 | Serial receive event pulse |
| stx_evt_i | input | 1 | Serial transmit event pulse |
| trap_req_i | input | 1 | Software trap request pulse |
| reset_req_i | input | 1 | Reset request pulse |
| core_busy_i | input | 1 | High while the current instruction is not at a boundary |
| gie_set_i | input | 1 | Global enable set command |
| gie_clr_i | input | 1 | Global enable clear command |
| wr_en_i | input | 1 | Data-space write strobe |
| wr_addr_i | input | 16 | Data-space write address |
| wr_data_i | input | 16 | Data-space write data |
| ack_o | output | 1 | One-cycle acknowledge of a take |
| vec_o | output | 16 | Vector address of the last take |
| flags_o | output | 6 | Flag register |
| mask_o | output | 6 | Mask register |
| gie_o | output | 1 | Global enable |

## Verification
The bench builds the block with its defaults: three external lines, two synchronizer stages, a vector stride of 2 and the mask at address 4. With these values every flag position, all eight vector codes and the full synchronizer latency can be reached from the ports. Raising several sources inside one busy window and then releasing busy shows the priority order. Re-arming the global enable after each take exposes the pending sources one at a time, so each flag clear can be seen at the flags output.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned CODE_W = 4;

  // Index of the lowest set bit; 0 when none is set.
  function automatic int unsigned lowest_index(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  function automatic logic [31:0] vector_for(input logic [CODE_W-1:0] code,
                                             input int unsigned base,
                                             input int unsigned stride);
    return 32'(base + 32'(code) * stride);
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sr_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], async_i};
      last_q <= sr_q[STAGES-1];
    end
  end

  assign rise_o = sr_q[STAGES-1] & ~last_q;

  // R1: one detection per edge
  a_r1_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int unsigned NF = 6
) (
  input  logic              busy_i,
  input  logic              rst_pend_i,
  input  logic              trap_pend_i,
  input  logic              gie_i,
  input  logic [NF-1:0]     flags_i,
  input  logic [NF-1:0]     mask_i,
  output logic              take_o,
  output logic              take_rst_o,
  output logic              take_trap_o,
  output logic [NF-1:0]     sel_o,
  output logic [CODE_W-1:0] code_o
);
  logic [NF-1:0] eligible;
  int unsigned   idx;

  always_comb begin
    eligible    = flags_i & mask_i & {NF{gie_i}};
    idx         = lowest_index(32'(eligible));
    take_o      = 1'b0;
    take_rst_o  = 1'b0;
    take_trap_o = 1'b0;
    sel_o       = '0;
    code_o      = '0;
    if (!busy_i) begin
      if (rst_pend_i) begin
        take_o     = 1'b1;
        take_rst_o = 1'b1;
      end else if (trap_pend_i) begin
        take_o      = 1'b1;
        take_trap_o = 1'b1;
        code_o      = CODE_W'(NF + 1);
      end else if (|eligible) begin
        take_o     = 1'b1;
        sel_o[idx] = 1'b1;
        code_o     = CODE_W'(idx + 1);
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_EXT     = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned VEC_BASE    = 0,
  parameter int unsigned VEC_STRIDE  = 2,
  parameter int unsigned MASK_ADDR   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_EXT-1:0]      ext_irq_i,
  input  logic                    tmr_evt_i,
  input  logic                    srx_evt_i,
  input  logic                    stx_evt_i,
  input  logic                    trap_req_i,
  input  logic                    reset_req_i,
  input  logic                    core_busy_i,
  input  logic                    gie_set_i,
  input  logic                    gie_clr_i,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  output logic                    ack_o,
  output logic [ADDR_W-1:0]       vec_o,
  output logic [NUM_EXT+2:0]      flags_o,
  output logic [NUM_EXT+2:0]      mask_o,
  output logic                    gie_o
);
  localparam int unsigned NF = NUM_EXT + 3;

  logic [NUM_EXT-1:0] ext_rise;
  logic [NF-1:0]      events;
  logic [NF-1:0]      flags_q, mask_q, sel;
  logic               gie_q, rst_pend_q, trap_pend_q, ack_q;
  logic               take, take_rst, take_trap, mask_hit;
  logic [CODE_W-1:0]  code, code_q;
  logic [ADDR_W-1:0]  vec_q;

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
    irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(ext_irq_i[g]),
      .rise_o (ext_rise[g])
    );
  end

  assign events   = {stx_evt_i, srx_evt_i, tmr_evt_i, ext_rise};
  assign mask_hit = wr_en_i && (wr_addr_i == ADDR_W'(MASK_ADDR));

  irq_arbiter #(.NF(NF)) u_arb (
    .busy_i     (core_busy_i),
    .rst_pend_i (rst_pend_q),
    .trap_pend_i(trap_pend_q),
    .gie_i      (gie_q),
    .flags_i    (flags_q),
    .mask_i     (mask_q),
    .take_o     (take),
    .take_rst_o (take_rst),
    .take_trap_o(take_trap),
    .sel_o      (sel),
    .code_o     (code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q     <= '0;
      mask_q      <= '0;
      gie_q       <= 1'b0;
      rst_pend_q  <= 1'b0;
      trap_pend_q <= 1'b0;
      ack_q       <= 1'b0;
      code_q      <= '0;
      vec_q       <= '0;
    end else begin
      flags_q     <= (flags_q & ~sel) | events;
      rst_pend_q  <= (rst_pend_q & ~take_rst) | reset_req_i;
      trap_pend_q <= (trap_pend_q & ~take_trap) | trap_req_i;
      if (mask_hit) mask_q <= wr_data_i[NF-1:0];
      if (take || gie_clr_i) gie_q <= 1'b0;
      else if (gie_set_i)    gie_q <= 1'b1;
      ack_q <= take;
      if (take) begin
        code_q <= code;
        vec_q  <= vector_for(code, VEC_BASE, VEC_STRIDE)[ADDR_W-1:0];
      end
    end
  end

  assign ack_o   = ack_q;
  assign vec_o   = vec_q;
  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign gie_o   = gie_q;

  // R5: a busy cycle is never a take cycle
  a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    core_busy_i |=> !ack_o);
  // R7: every take leaves the global enable off
  a_r7_gie_off_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !gie_o);
  // R4: a maskable take needs the enable on in the cycle before
  a_r4_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && code_q >= CODE_W'(1) && code_q <= CODE_W'(NF)) |-> $past(gie_o));
  // R2: mask changes only through a write at its address
  a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_hit |=> $stable(mask_o));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ext_irq = '0;
  logic        tmr = 0, srx = 0, stx = 0, trap = 0, rreq = 0, busy = 0;
  logic        gset = 0, gclr = 0, wen = 0;
  logic [15:0] waddr = '0, wdata = '0;
  logic        ack, gie;
  logic [15:0] vec;
  logic [5:0]  flags, mask;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq), .tmr_evt_i(tmr),
    .srx_evt_i(srx), .stx_evt_i(stx), .trap_req_i(trap), .reset_req_i(rreq),
    .core_busy_i(busy), .gie_set_i(gset), .gie_clr_i(gclr), .wr_en_i(wen),
    .wr_addr_i(waddr), .wr_data_i(wdata), .ack_o(ack), .vec_o(vec),
    .flags_o(flags), .mask_o(mask), .gie_o(gie)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side of the scoreboard: code -> 2*code
  task automatic expect_code(input int code);
    exp_q.push_back(16'(2 * code));
  endtask

  task automatic pulse_evt(input int which);
    case (which)
      0: tmr = 1;  1: srx = 1;  2: stx = 1;  3: trap = 1;  default: rreq = 1;
    endcase
    tick(1);
    tmr = 0; srx = 0; stx = 0; trap = 0; rreq = 0;
  endtask

  task automatic write(input logic [15:0] a, input logic [15:0] d);
    wen = 1; waddr = a; wdata = d;
    tick(1);
    wen = 0;
  endtask

  task automatic gie_on();
    gset = 1; tick(1); gset = 0;
  endtask

  // monitor: each acknowledge pops and compares one expected vector (R6)
  always @(negedge clk) begin
    if (rst_n && ack) begin
      if (exp_q.size() == 0) chk("R6 unexpected ack vec", vec, 16'hFFFF);
      else chk("R6 vector", vec, exp_q.pop_front());
    end
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    chk("R9 flags", flags, 0); chk("R9 mask", mask, 0);
    chk("R9 gie", gie, 0);     chk("R9 ack", ack, 0);

    // R2: mask load at address 4, other address ignored
    write(16'd4, 16'hFF3F);
    chk("R2 mask load", mask, 6'h3F);
    write(16'd5, 16'h0000);
    chk("R2 other addr ignored", mask, 6'h3F);

    // R4: flag pending but global enable off -> no take
    pulse_evt(0);
    tick(3);
    chk("R4 timer held gie off", flags, 6'h08);
    expect_code(4);
    gie_on();
    tick(3);
    chk("R7 timer flag cleared", flags, 6'h00);
    chk("R7 gie cleared", gie, 0);

    // R5/R3: several sources raised while busy
    busy = 1;
    gie_on();
    ext_irq = 3'b101;
    pulse_evt(1);
    tick(5);
    chk("R1/R5 flags held while busy", flags, 6'h15);
    chk("R5 gie still on", gie, 1);
    expect_code(1);
    busy = 0;
    tick(3);
    chk("R3 ext0 first, flags left", flags, 6'h14);
    expect_code(3);
    gie_on(); tick(3);
    chk("R3 ext2 next", flags, 6'h10);
    expect_code(5);
    gie_on(); tick(3);
    chk("R3 rx last", flags, 6'h00);
    tick(4);
    chk("R1 held level no re-flag", flags, 6'h00);
    ext_irq = 3'b000;

    // R4: masked source held until unmasked
    write(16'd4, 16'h0037);
    gie_on();
    pulse_evt(0);
    tick(3);
    chk("R4 masked timer held", flags, 6'h08);
    chk("R4 gie untouched", gie, 1);
    expect_code(4);
    write(16'd4, 16'h003F);
    tick(3);
    chk("R4 unmasked timer taken", flags, 6'h00);

    // R8/R3: reset and trap with enable off, behind busy
    busy = 1;
    trap = 1; rreq = 1; tick(1); trap = 0; rreq = 0;
    tick(3);
    chk("R5 nothing taken while busy", exp_q.size(), 0);
    expect_code(0);
    expect_code(7);
    busy = 0;
    tick(4);
    chk("R8 reset and trap taken", exp_q.size(), 0);

    // R1/R3: ext1 beats stx when both pending
    busy = 1;
    gie_on();
    ext_irq = 3'b010;
    pulse_evt(2);
    tick(4);
    chk("R1 ext1 and stx flags", flags, 6'h22);
    expect_code(2);
    busy = 0;
    tick(3);
    expect_code(6);
    gie_on(); tick(3);
    chk("R3 stx served last", flags, 6'h00);
    ext_irq = 3'b000;

    // R7: clear wins over set
    gset = 1; gclr = 1; tick(1); gset = 0; gclr = 0;
    chk("R7 clear wins", gie, 0);
    tick(2);
    chk("R6 all expected vectors seen", exp_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule